// File: doc/BRIEF.md
# Long-Displacement Branch Resolver with Call Frame Update

This block resolves one relative branch with a very wide displacement per request. Given the current instruction pointer, a 60-bit displacement counted in 16-byte instruction bundles, a branch kind (plain conditional or call) and the qualifying predicate, it produces the next instruction pointer and a taken flag one clock later. All results are registered and qualified by a single response strobe.

A taken call does more than link a return address. It records the caller's whole register-frame descriptor, its epilog count and its privilege level in a saved-state write. It also shrinks the live frame down to its output area and clears every rotation base. The actual spill of the dropped locals is left to a neighbouring register-stack engine, which receives a one-cycle preserve request with the number of locals.

When the long-branch capability is strapped off, the request raises only an illegal-operation fault. A taken branch to an address outside the implemented virtual or physical space raises an unimplemented-address trap, unless an implementation-level fault mode handles it elsewhere. A taken branch with single-step branch tracing enabled raises a taken-branch trap.

Top module: `farjump_resolver`

## Requirements
- R1: On a taken branch the next pointer is `cur_ip + (disp << 4)`, modulo 2^IP_W.
- R2: With the capability enabled, the branch is taken exactly when `pred` is 1, for both kinds. When it is not taken, the next pointer is `cur_ip + 16`, and `link_we`, `prev_we`, `frame_we` and `preserve_req` stay 0.
- R3: On a taken call, `link_we` is 1, `link_data` is `cur_ip + 16` and `link_sel_q` repeats `link_sel`. A taken conditional branch writes no link.
- R4: On a taken call, `prev_we` is 1. `prev_frame` holds the current frame packed as size-of-frame in bits 6:0, locals 13:7, rotating 20:14, general base 27:21, floating base 34:28 and predicate base 40:35. `prev_ec` holds `cur_ec` and `prev_pl` holds `cur_pl`.
- R5: On a taken call, `frame_we` is 1. The new frame size is `cur_sof - cur_sol`, and locals, rotating size and all three rotation bases are 0. `preserve_req` pulses with `preserve_cnt = cur_sol`. In every other resolved case the `new_*` outputs repeat the current frame.
- R6: With `en_long` at 0, `illegal_fault` is 1, `taken` is 0, the next pointer is `cur_ip`, and no write, preserve or trap strobe is raised.
- R7: `unimpl_trap` is 1 only on a taken branch with `uia_fault_mode` at 0 whose target is unimplemented. With `xlate_on` at 1, a target is implemented when its bits IP_W-4 down to VA_W-1 are all equal. With `xlate_on` at 0, a target is implemented when its bits IP_W-2 down to PA_W are all 0.
- R8: `taken_trap` is 1 exactly when the branch is taken and `trap_taken_en` is 1. The pointer update still happens.
- R9: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` at 1, and all strobes are 0 whenever `rsp_valid` is 0. Reset clears `rsp_valid` and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| cur_ip | input | IP_W | Current instruction pointer |
| disp | input | IMM_W | Displacement in 16-byte bundles |
| is_call | input | 1 | 1 = call, 0 = conditional |
| pred | input | 1 | Qualifying predicate value |
| link_sel | input | LSEL_W | Destination index for the return link |
| en_long | input | 1 | Long-branch capability strap |
| xlate_on | input | 1 | Instruction translation enabled |
| uia_fault_mode | input | 1 | Unimplemented-address check handled elsewhere |
| trap_taken_en | input | 1 | Taken-branch trap enable |
| cur_sof | input | 7 | Current frame size |
| cur_sol | input | 7 | Current locals size |
| cur_sor | input | 7 | Current rotating size |
| cur_rot_gr | input | 7 | Current general rotation base |
| cur_rot_fr | input | 7 | Current floating rotation base |
| cur_rot_pr | input | 6 | Current predicate rotation base |
| cur_ec | input | EC_W | Current epilog count |
| cur_pl | input | PL_W | Current privilege level |
| rsp_valid | output | 1 | Response strobe |
| next_ip | output | IP_W | Resolved next pointer |
| taken | output | 1 | Branch taken |
| link_we | output | 1 | Return-link write |
| link_sel_q | output | LSEL_W | Return-link destination |
| link_data | output | IP_W | Return address |
| prev_we | output | 1 | Saved-state write |
| prev_frame | output | 41 | Saved frame descriptor |
| prev_ec | output | EC_W | Saved epilog count |
| prev_pl | output | PL_W | Saved privilege level |
| frame_we | output | 1 | Frame descriptor update |
| new_sof | output | 7 | Updated frame size |
| new_sol | output | 7 | Updated locals size |
| new_sor | output | 7 | Updated rotating size |
| new_rot_gr | output | 7 | Updated general base |
| new_rot_fr | output | 7 | Updated floating base |
| new_rot_pr | output | 6 | Updated predicate base |
| preserve_req | output | 1 | Request to preserve dropped locals |
| preserve_cnt | output | 7 | Number of locals to preserve |
| illegal_fault | output | 1 | Illegal-operation fault |
| unimpl_trap | output | 1 | Unimplemented-address trap |
| taken_trap | output | 1 | Taken-branch trap |

## Verification
The bench builds the block with IP_W=64, IMM_W=60, VA_W=51 and PA_W=50. With these widths, displacements derived directly from chosen targets land just inside and just outside both implemented spaces. Examples are a target with only bit 50 set, a sign-extended virtual target with bits 60:50 all set, and an uncached-region physical target using bit 63. Calls are run with zero locals, locals equal to the frame size and mid-range frames, so the shrink arithmetic is checked at both ends.

// File: rtl/farjump_pkg.sv
package farjump_pkg;

  parameter int SZ_W   = 7;
  parameter int ROTG_W = 7;
  parameter int ROTF_W = 7;
  parameter int ROTP_W = 6;
  parameter int FRAME_W = 3 * SZ_W + ROTG_W + ROTF_W + ROTP_W;

  // Packed so that size-of-frame lands in the low bits of the saved image.
  typedef struct packed {
    logic [ROTP_W-1:0] rot_pr;
    logic [ROTF_W-1:0] rot_fr;
    logic [ROTG_W-1:0] rot_gr;
    logic [SZ_W-1:0]   sor;
    logic [SZ_W-1:0]   sol;
    logic [SZ_W-1:0]   sof;
  } frame_t;

  typedef enum logic {KIND_COND = 1'b0, KIND_CALL = 1'b1} br_kind_e;

endpackage

// File: rtl/farjump_target.sv
module farjump_target #(
  parameter int IP_W       = 64,
  parameter int IMM_W      = 60,
  parameter int SLOT_SHIFT = 4
) (
  input  logic [IP_W-1:0]  base_ip,
  input  logic [IMM_W-1:0] disp,
  output logic [IP_W-1:0]  target,
  output logic [IP_W-1:0]  fall_thru
);
  localparam int SCALED_W = IMM_W + SLOT_SHIFT;
  localparam logic [IP_W-1:0] SLOT_BYTES = IP_W'(1) << SLOT_SHIFT;

  logic [SCALED_W-1:0] scaled;
  logic [IP_W-1:0]     offset;

  always_comb begin
    scaled = {disp, {SLOT_SHIFT{1'b0}}};
    offset = IP_W'(scaled);
  end

  generate
    if (SCALED_W > IP_W) begin : g_wide_unused
      logic unused_hi;
      assign unused_hi = ^scaled[SCALED_W-1:IP_W];
    end
  endgenerate

  assign target    = base_ip + offset;
  assign fall_thru = base_ip + SLOT_BYTES;

endmodule

// File: rtl/farjump_addr_check.sv
module farjump_addr_check #(
  parameter int IP_W = 64,
  parameter int VA_W = 51,
  parameter int PA_W = 50
) (
  input  logic [IP_W-1:0] addr,
  input  logic            xlate_on,
  output logic            implemented
);
  localparam logic [IP_W-1:0] ONE = IP_W'(1);
  // Virtual: bits IP_W-4 .. VA_W-1 must be a sign extension.
  localparam logic [IP_W-1:0] VMASK = (ONE << (IP_W - 3)) - (ONE << (VA_W - 1));
  // Physical: bits IP_W-2 .. PA_W must be clear.
  localparam logic [IP_W-1:0] PMASK = (ONE << (IP_W - 1)) - (ONE << PA_W);

  logic [IP_W-1:0] vbits;
  logic [IP_W-1:0] pbits;
  logic            virt_ok;
  logic            phys_ok;

  always_comb begin
    vbits   = addr & VMASK;
    pbits   = addr & PMASK;
    virt_ok = (vbits == '0) || (vbits == VMASK);
    phys_ok = (pbits == '0);
    implemented = xlate_on ? virt_ok : phys_ok;
  end

endmodule

// File: rtl/farjump_frame.sv
module farjump_frame
  import farjump_pkg::*;
(
  input  frame_t          cur,
  input  logic            do_call,
  output frame_t          nxt,
  output logic [SZ_W-1:0] spill_cnt
);
  logic [SZ_W-1:0] outs_sz;

  always_comb begin
    // Locals never exceed the frame; clamp to keep a malformed input bounded.
    outs_sz   = (cur.sol > cur.sof) ? '0 : (cur.sof - cur.sol);
    spill_cnt = cur.sol;
    nxt       = cur;
    if (do_call) begin
      nxt.sof    = outs_sz;
      nxt.sol    = '0;
      nxt.sor    = '0;
      nxt.rot_gr = '0;
      nxt.rot_fr = '0;
      nxt.rot_pr = '0;
    end
  end

endmodule

// File: rtl/farjump_resolver.sv
module farjump_resolver
  import farjump_pkg::*;
#(
  parameter int IP_W   = 64,
  parameter int IMM_W  = 60,
  parameter int VA_W   = 51,
  parameter int PA_W   = 50,
  parameter int LSEL_W = 3,
  parameter int EC_W   = 6,
  parameter int PL_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [IP_W-1:0]     cur_ip,
  input  logic [IMM_W-1:0]    disp,
  input  logic                is_call,
  input  logic                pred,
  input  logic [LSEL_W-1:0]   link_sel,
  input  logic                en_long,
  input  logic                xlate_on,
  input  logic                uia_fault_mode,
  input  logic                trap_taken_en,
  input  logic [6:0]          cur_sof,
  input  logic [6:0]          cur_sol,
  input  logic [6:0]          cur_sor,
  input  logic [6:0]          cur_rot_gr,
  input  logic [6:0]          cur_rot_fr,
  input  logic [5:0]          cur_rot_pr,
  input  logic [EC_W-1:0]     cur_ec,
  input  logic [PL_W-1:0]     cur_pl,
  output logic                rsp_valid,
  output logic [IP_W-1:0]     next_ip,
  output logic                taken,
  output logic                link_we,
  output logic [LSEL_W-1:0]   link_sel_q,
  output logic [IP_W-1:0]     link_data,
  output logic                prev_we,
  output logic [40:0]         prev_frame,
  output logic [EC_W-1:0]     prev_ec,
  output logic [PL_W-1:0]     prev_pl,
  output logic                frame_we,
  output logic [6:0]          new_sof,
  output logic [6:0]          new_sol,
  output logic [6:0]          new_sor,
  output logic [6:0]          new_rot_gr,
  output logic [6:0]          new_rot_fr,
  output logic [5:0]          new_rot_pr,
  output logic                preserve_req,
  output logic [6:0]          preserve_cnt,
  output logic                illegal_fault,
  output logic                unimpl_trap,
  output logic                taken_trap
);

  // ---------------- datapath pieces ----------------
  frame_t          fr_cur;
  frame_t          fr_nxt;
  logic [SZ_W-1:0] spill_cnt;
  logic [IP_W-1:0] tgt_ip;
  logic [IP_W-1:0] seq_ip;
  logic            tgt_impl;
  br_kind_e        kind;

  always_comb begin
    fr_cur.sof    = cur_sof;
    fr_cur.sol    = cur_sol;
    fr_cur.sor    = cur_sor;
    fr_cur.rot_gr = cur_rot_gr;
    fr_cur.rot_fr = cur_rot_fr;
    fr_cur.rot_pr = cur_rot_pr;
    kind          = is_call ? KIND_CALL : KIND_COND;
  end

  farjump_target #(.IP_W(IP_W), .IMM_W(IMM_W), .SLOT_SHIFT(4)) u_target (
    .base_ip   (cur_ip),
    .disp      (disp),
    .target    (tgt_ip),
    .fall_thru (seq_ip)
  );

  farjump_addr_check #(.IP_W(IP_W), .VA_W(VA_W), .PA_W(PA_W)) u_addr (
    .addr        (tgt_ip),
    .xlate_on    (xlate_on),
    .implemented (tgt_impl)
  );

  logic d_take;
  logic d_call_take;

  farjump_frame u_frame (
    .cur       (fr_cur),
    .do_call   (d_call_take),
    .nxt       (fr_nxt),
    .spill_cnt (spill_cnt)
  );

  // ---------------- next-state logic ----------------
  logic [IP_W-1:0] d_next_ip;
  logic            d_illegal;
  logic            d_unimpl;
  logic            d_ttrap;

  always_comb begin
    d_take      = en_long & pred;
    d_call_take = d_take & (kind == KIND_CALL);
    d_illegal   = ~en_long;
    d_unimpl    = d_take & ~uia_fault_mode & ~tgt_impl;
    d_ttrap     = d_take & trap_taken_en;
    if (!en_long)     d_next_ip = cur_ip;
    else if (d_take)  d_next_ip = tgt_ip;
    else              d_next_ip = seq_ip;
  end

  // ---------------- registers ----------------
  // Strobes: reset, then follow the request every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      taken         <= 1'b0;
      link_we       <= 1'b0;
      prev_we       <= 1'b0;
      frame_we      <= 1'b0;
      preserve_req  <= 1'b0;
      illegal_fault <= 1'b0;
      unimpl_trap   <= 1'b0;
      taken_trap    <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      taken         <= req_valid & d_take;
      link_we       <= req_valid & d_call_take;
      prev_we       <= req_valid & d_call_take;
      frame_we      <= req_valid & d_call_take;
      preserve_req  <= req_valid & d_call_take;
      illegal_fault <= req_valid & d_illegal;
      unimpl_trap   <= req_valid & d_unimpl;
      taken_trap    <= req_valid & d_ttrap;
    end
  end

  // Payload: loaded only when a request is present.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_ip      <= '0;
      link_sel_q   <= '0;
      link_data    <= '0;
      prev_frame   <= '0;
      prev_ec      <= '0;
      prev_pl      <= '0;
      new_sof      <= '0;
      new_sol      <= '0;
      new_sor      <= '0;
      new_rot_gr   <= '0;
      new_rot_fr   <= '0;
      new_rot_pr   <= '0;
      preserve_cnt <= '0;
    end else if (req_valid) begin
      next_ip      <= d_next_ip;
      link_sel_q   <= link_sel;
      link_data    <= seq_ip;
      prev_frame   <= fr_cur;
      prev_ec      <= cur_ec;
      prev_pl      <= cur_pl;
      new_sof      <= fr_nxt.sof;
      new_sol      <= fr_nxt.sol;
      new_sor      <= fr_nxt.sor;
      new_rot_gr   <= fr_nxt.rot_gr;
      new_rot_fr   <= fr_nxt.rot_fr;
      new_rot_pr   <= fr_nxt.rot_pr;
      preserve_cnt <= spill_cnt;
    end
  end

endmodule

// File: rtl/farjump_checker.sv
module farjump_checker #(
  parameter int IP_W  = 64,
  parameter int IMM_W = 60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [IP_W-1:0]  cur_ip,
  input logic [IMM_W-1:0] disp,
  input logic             en_long,
  input logic             rsp_valid,
  input logic [IP_W-1:0]  next_ip,
  input logic             taken,
  input logic             link_we,
  input logic             prev_we,
  input logic             frame_we,
  input logic             preserve_req,
  input logic [6:0]       new_sol,
  input logic [6:0]       new_sor,
  input logic [6:0]       new_rot_gr,
  input logic [6:0]       new_rot_fr,
  input logic [5:0]       new_rot_pr,
  input logic             illegal_fault,
  input logic             unimpl_trap,
  input logic             taken_trap
);

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_rsp_without_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_valid || taken || link_we || illegal_fault || unimpl_trap || taken_trap));

  assert_target_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && en_long) |=> (!taken || next_ip == $past(cur_ip) + {$past(disp), 4'b0000}));

  assert_not_taken_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !taken) |-> !(link_we || prev_we || frame_we || preserve_req));

  assert_link_needs_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (taken && prev_we && frame_we));

  assert_frame_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_we |-> (new_sol == '0 && new_sor == '0 && new_rot_gr == '0 &&
                  new_rot_fr == '0 && new_rot_pr == '0 && preserve_req));

  assert_fault_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_fault |-> !(taken || link_we || frame_we || unimpl_trap || taken_trap));

  assert_unimpl_needs_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_trap |-> taken);

  assert_trap_needs_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    taken_trap |-> taken);

endmodule

bind farjump_resolver farjump_checker #(.IP_W(IP_W), .IMM_W(IMM_W)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .cur_ip        (cur_ip),
  .disp          (disp),
  .en_long       (en_long),
  .rsp_valid     (rsp_valid),
  .next_ip       (next_ip),
  .taken         (taken),
  .link_we       (link_we),
  .prev_we       (prev_we),
  .frame_we      (frame_we),
  .preserve_req  (preserve_req),
  .new_sol       (new_sol),
  .new_sor       (new_sor),
  .new_rot_gr    (new_rot_gr),
  .new_rot_fr    (new_rot_fr),
  .new_rot_pr    (new_rot_pr),
  .illegal_fault (illegal_fault),
  .unimpl_trap   (unimpl_trap),
  .taken_trap    (taken_trap)
);

// File: tb/test_farjump_resolver.sv
module test_farjump_resolver;
  localparam int IP_W = 64, IMM_W = 60, VA_W = 51, PA_W = 50;
  localparam int LSEL_W = 3, EC_W = 6, PL_W = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, is_call, pred, en_long, xlate_on, uia_fault_mode, trap_taken_en;
  logic [IP_W-1:0] cur_ip;
  logic [IMM_W-1:0] disp;
  logic [LSEL_W-1:0] link_sel;
  logic [6:0] cur_sof, cur_sol, cur_sor, cur_rot_gr, cur_rot_fr;
  logic [5:0] cur_rot_pr;
  logic [EC_W-1:0] cur_ec;
  logic [PL_W-1:0] cur_pl;

  logic rsp_valid, taken, link_we, prev_we, frame_we, preserve_req;
  logic illegal_fault, unimpl_trap, taken_trap;
  logic [IP_W-1:0] next_ip, link_data;
  logic [LSEL_W-1:0] link_sel_q;
  logic [40:0] prev_frame;
  logic [EC_W-1:0] prev_ec;
  logic [PL_W-1:0] prev_pl;
  logic [6:0] new_sof, new_sol, new_sor, new_rot_gr, new_rot_fr, preserve_cnt;
  logic [5:0] new_rot_pr;

  farjump_resolver #(.IP_W(IP_W), .IMM_W(IMM_W), .VA_W(VA_W), .PA_W(PA_W),
                     .LSEL_W(LSEL_W), .EC_W(EC_W), .PL_W(PL_W)) i_farjump_resolver (.*);

  int total = 0;
  int bad   = 0;

  task automatic chk(input string what, input logic [IP_W-1:0] got, input logic [IP_W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic set_defaults();
    cur_ip = 64'h0000_0000_0040_1000; disp = '0; is_call = 0; pred = 0; link_sel = 3'd2;
    en_long = 1; xlate_on = 1; uia_fault_mode = 0; trap_taken_en = 0;
    cur_sof = 7'd20; cur_sol = 7'd12; cur_sor = 7'd8; cur_rot_gr = 7'd3; cur_rot_fr = 7'd5;
    cur_rot_pr = 6'd7; cur_ec = 6'd9; cur_pl = 2'd3;
  endtask

  // Drive a request, then check every output against a model built from the requirements.
  task automatic run_and_check(input string name);
    logic [IP_W-1:0] tgt, seq, e_ip, vb, pb;
    logic e_take, e_call, e_impl, e_unimpl;
    logic [40:0] e_frame;
    tgt    = cur_ip + {disp, 4'b0000};
    seq    = cur_ip + 64'd16;
    e_take = en_long && pred;
    e_call = e_take && is_call;
    vb     = tgt & (((64'd1 << (IP_W-3)) - (64'd1 << (VA_W-1))));
    pb     = tgt & (((64'd1 << (IP_W-1)) - (64'd1 << PA_W)));
    e_impl = xlate_on ? (vb == 0 || vb == ((64'd1 << (IP_W-3)) - (64'd1 << (VA_W-1)))) : (pb == 0);
    e_unimpl = e_take && !uia_fault_mode && !e_impl;
    e_ip   = !en_long ? cur_ip : (e_take ? tgt : seq);
    e_frame = {cur_rot_pr, cur_rot_fr, cur_rot_gr, cur_sor, cur_sol, cur_sof};

    @(negedge clk) req_valid = 1'b1;
    @(negedge clk) req_valid = 1'b0;
    chk({name, " R9 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({name, " R1 next_ip"}, next_ip, e_ip);
    chk({name, " R2 taken"}, 64'(taken), 64'(e_take));
    chk({name, " R3 link_we"}, 64'(link_we), 64'(e_call));
    chk({name, " R4 prev_we"}, 64'(prev_we), 64'(e_call));
    chk({name, " R5 frame_we"}, 64'(frame_we), 64'(e_call));
    chk({name, " R5 preserve_req"}, 64'(preserve_req), 64'(e_call));
    chk({name, " R6 illegal_fault"}, 64'(illegal_fault), 64'(!en_long));
    chk({name, " R7 unimpl_trap"}, 64'(unimpl_trap), 64'(e_unimpl));
    chk({name, " R8 taken_trap"}, 64'(taken_trap), 64'(e_take && trap_taken_en));
    if (e_call) begin
      chk({name, " R3 link_data"}, link_data, seq);
      chk({name, " R3 link_sel_q"}, 64'(link_sel_q), 64'(link_sel));
      chk({name, " R4 prev_frame"}, 64'(prev_frame), 64'(e_frame));
      chk({name, " R4 prev_ec"}, 64'(prev_ec), 64'(cur_ec));
      chk({name, " R4 prev_pl"}, 64'(prev_pl), 64'(cur_pl));
      chk({name, " R5 new_sof"}, 64'(new_sof), 64'(cur_sof - cur_sol));
      chk({name, " R5 cleared fields"}, 64'({new_sol, new_sor, new_rot_gr, new_rot_fr, new_rot_pr}), 64'd0);
      chk({name, " R5 preserve_cnt"}, 64'(preserve_cnt), 64'(cur_sol));
    end else begin
      chk({name, " R5 frame kept"},
          64'({new_rot_pr, new_rot_fr, new_rot_gr, new_sor, new_sol, new_sof}), 64'(e_frame));
    end
    @(negedge clk);
    chk({name, " R9 rsp_valid drop"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("reset R9 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("reset R9 strobes", 64'({taken, link_we, prev_we, frame_we, preserve_req,
        illegal_fault, unimpl_trap, taken_trap}), 64'd0);
  endtask

  task automatic t_cond_taken();
    set_defaults(); pred = 1; disp = 60'h0000_0000_0012_345; run_and_check("cond_taken");
    set_defaults(); pred = 1; disp = {IMM_W{1'b1}}; run_and_check("cond_backward");
  endtask

  task automatic t_not_taken();
    set_defaults(); pred = 0; disp = 60'h123; run_and_check("cond_not_taken");
    set_defaults(); pred = 0; is_call = 1; disp = 60'h456; run_and_check("call_not_taken");
  endtask

  task automatic t_call();
    set_defaults(); pred = 1; is_call = 1; disp = 60'h7_0000; link_sel = 3'd5; run_and_check("call_mid");
    set_defaults(); pred = 1; is_call = 1; cur_sol = 7'd0; cur_sof = 7'd96; run_and_check("call_no_locals");
    set_defaults(); pred = 1; is_call = 1; cur_sol = 7'd96; cur_sof = 7'd96; cur_rot_pr = 6'h3f;
    run_and_check("call_all_locals");
  endtask

  task automatic t_disabled();
    set_defaults(); en_long = 0; pred = 1; is_call = 1; trap_taken_en = 1; disp = 60'h4000_0000_0000;
    run_and_check("disabled_R6");
  endtask

  task automatic t_unimpl();
    // virtual: bit 50 alone breaks the sign extension; bits 60:50 all set are fine
    set_defaults(); cur_ip = 0; pred = 1; disp = 64'h0004_0000_0000_0000 >> 4; run_and_check("virt_bad_R7");
    set_defaults(); cur_ip = 0; pred = 1; disp = 64'h1FFC_0000_0000_1000 >> 4; run_and_check("virt_ok_R7");
    set_defaults(); cur_ip = 0; pred = 1; disp = 64'hE000_0000_0000_2000 >> 4; run_and_check("virt_region_R7");
    // physical
    set_defaults(); cur_ip = 0; pred = 1; xlate_on = 0; disp = 64'h0004_0000_0000_0000 >> 4; run_and_check("phys_bad_R7");
    set_defaults(); cur_ip = 0; pred = 1; xlate_on = 0; disp = 64'h8003_FFFF_FFFF_FFF0 >> 4; run_and_check("phys_ok_R7");
    // fault mode suppresses, not-taken never traps
    set_defaults(); cur_ip = 0; pred = 1; uia_fault_mode = 1; disp = 64'h0004_0000_0000_0000 >> 4; run_and_check("fault_mode_R7");
    set_defaults(); cur_ip = 0; pred = 0; disp = 64'h0004_0000_0000_0000 >> 4; run_and_check("not_taken_R7");
  endtask

  task automatic t_taken_trap();
    set_defaults(); pred = 1; trap_taken_en = 1; disp = 60'h99; run_and_check("ttrap_R8");
    set_defaults(); pred = 0; trap_taken_en = 1; disp = 60'h99; run_and_check("ttrap_not_taken_R8");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      set_defaults();
      cur_ip = {$urandom, $urandom} & ~64'hF;
      disp = {$urandom, $urandom} & {IMM_W{1'b1}};
      pred = 1'($urandom); is_call = 1'($urandom); xlate_on = 1'($urandom);
      uia_fault_mode = 1'($urandom); trap_taken_en = 1'($urandom);
      cur_sof = 7'($urandom % 97); cur_sol = 7'($urandom % (32'(cur_sof) + 1));
      cur_sor = 7'($urandom); cur_rot_gr = 7'($urandom); cur_rot_fr = 7'($urandom);
      cur_rot_pr = 6'($urandom); cur_ec = 6'($urandom); cur_pl = 2'($urandom);
      link_sel = 3'($urandom);
      run_and_check("random");
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0;
    set_defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cond_taken();
    t_not_taken();
    t_call();
    t_disabled();
    t_unimpl();
    t_taken_trap();
    t_random();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R9 got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule